// File: doc/BRIEF.md
# Miss Target Queue Pair

This block keeps the requests parked on one outstanding cache miss. It has two ordered lists of targets, an active list and a deferred list. Each target holds a 2-bit source code, an order tag, a request identifier, an allocate-on-fill bit and a pending-marker bit. When the fill for the miss returns, the block decides which active targets the response can satisfy. It copies them into an output stream and keeps the others in the active list, in their original order.

A plain response serves the whole active list. A response that also invalidates the line serves the head target and every snoop target, and leaves the remaining CPU targets queued so that they reissue. A promotion request moves the deferred targets behind whatever is still active. The served targets leave one per cycle on a valid/ready handshake. The first served target carries the OR of the allocate bits of the served set. Counts and OR-flags of both lists are always visible.

Top module: `mshr_tgt_lists`

## Requirements
- R1: After reset both lists are empty, out_valid is low, resp_ready is high, and every count and flag reads zero.
- R2: An insert with ins_defer=0 appends to the active list and one with ins_defer=1 appends to the deferred list. Targets keep the order in which they arrive. ins_stall rises and the insert is dropped when the chosen list already holds DEPTH targets, or when the same cycle accepts a response or carries a promotion request.
- R3: A response accepted with resp_inval=0 serves every active target in list order, and pri_cnt reads zero on the next cycle.
- R4: A response accepted with resp_inval=1 serves the head target and then every later target with source code 1 (snoop). Targets with source code 0 (CPU), 2 (prefetch) or 3 (reserved) stay in the active list in their relative order.
- R5: resp_err is high in the cycle a resp_inval=1 response is accepted if any of these holds: the active list is empty, the head's source is not 0, or a later active target has source 2 or 3.
- R6: Served targets leave one per cycle while out_ready is high. A stalled output holds steady. resp_ready stays low while any served target is still waiting.
- R7: out_first marks the first target of each served set. While out_first is high, out_alloc equals the OR of the allocate bits of every target in that set.
- R8: A promotion with an empty active list and a non-empty deferred list moves the whole deferred list into the active list, in order.
- R9: A promotion with a non-empty active list appends all deferred targets behind the active ones, provided the sum fits in DEPTH.
- R10: prom_none is high and no list changes when a promotion finds both lists empty or their sum above DEPTH. A promotion in a cycle that accepts a response is ignored.
- R11: clr_pend_pri clears the pending bit of every target in the active list at the end of that cycle, so pri_pend_any reads zero afterwards.
- R12: pri_cnt, def_cnt, pri_alloc_any, pri_pend_any and def_alloc_any always match the current contents of the lists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a target this cycle |
| ins_defer | input | 1 | 1 selects the deferred list |
| ins_src | input | 2 | Source: 0 CPU, 1 snoop, 2 prefetch, 3 reserved |
| ins_order | input | 8 | Order tag |
| ins_id | input | 6 | Request identifier |
| ins_alloc | input | 1 | Allocate-on-fill bit |
| ins_pend | input | 1 | Pending-marker bit |
| ins_stall | output | 1 | Insert dropped |
| resp_valid | input | 1 | Fill response arrives |
| resp_inval | input | 1 | Response carries an invalidation |
| resp_ready | output | 1 | Response can be accepted |
| resp_err | output | 1 | Illegal list contents for an invalidating response |
| promote_req | input | 1 | Move deferred targets to the active list |
| prom_none | output | 1 | Promotion moved nothing |
| clr_pend_pri | input | 1 | Clear pending bits of the active list |
| out_valid | output | 1 | Served target present |
| out_ready | input | 1 | Consumer takes the served target |
| out_src | output | 2 | Source of the served target |
| out_order | output | 8 | Order tag of the served target |
| out_id | output | 6 | Identifier of the served target |
| out_pend | output | 1 | Pending bit of the served target |
| out_first | output | 1 | First target of a served set |
| out_alloc | output | 1 | OR of allocate bits of the served set |
| pri_cnt | output | CW | Active list count |
| def_cnt | output | CW | Deferred list count |
| pri_alloc_any | output | 1 | Some active target has allocate set |
| pri_pend_any | output | 1 | Some active target has pending set |
| def_alloc_any | output | 1 | Some deferred target has allocate set |

CW is $clog2(DEPTH+1).

## Verification
The bench builds the block with DEPTH=4 instead of the default 8. With the smaller depth, full lists, dropped inserts and promotions that do not fit happen often under random traffic. The source mix is weighted toward CPU and snoop targets, with a few prefetch and reserved codes. This lets invalidating responses split lists in many patterns and still reach each error case.

// File: rtl/mshr_tl_pkg.sv
package mshr_tl_pkg;
    localparam int ORD_W = 8;
    localparam int ID_W  = 6;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_SNOOP = 2'd1,
        SRC_PREF  = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [ORD_W-1:0] ord;
        logic [ID_W-1:0]  id;
        logic             alloc;
        logic             pend;
    } tgt_t;

    // Whether an invalidating response serves the entry at position idx.
    function automatic logic inval_takes(int idx, src_e s);
        return (idx == 0) || (s == SRC_SNOOP);
    endfunction

    // Sources that may not sit behind the head on an invalidating response.
    function automatic logic tail_illegal(src_e s);
        return (s != SRC_CPU) && (s != SRC_SNOOP);
    endfunction
endpackage

// File: rtl/mshr_tl_list.sv
module mshr_tl_list
    import mshr_tl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  tgt_t          push_t,
    input  logic          load,
    input  tgt_t          load_vec [DEPTH],
    input  logic [CW-1:0] load_cnt,
    input  logic          clr_pend,
    output tgt_t          ents [DEPTH],
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          alloc_any,
    output logic          pend_any
);
    tgt_t          n_ents [DEPTH];
    logic [CW-1:0] n_cnt;

    assign full = (cnt == CW'(DEPTH));

    always_comb begin
        n_ents = ents;
        n_cnt  = cnt;
        if (load) begin
            n_ents = load_vec;
            n_cnt  = load_cnt;
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == cnt) n_ents[i] = push_t;
            n_cnt = cnt + 1'b1;
        end
        // Clear applies to whatever the list holds at the end of the cycle.
        if (clr_pend)
            for (int i = 0; i < DEPTH; i++) n_ents[i].pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else begin
            cnt  <= n_cnt;
            ents <= n_ents;
        end
    end

    always_comb begin
        alloc_any = 1'b0;
        pend_any  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt) begin
                alloc_any = alloc_any | ents[i].alloc;
                pend_any  = pend_any  | ents[i].pend;
            end
        end
    end
endmodule

// File: rtl/mshr_tl_split.sv
module mshr_tl_split
    import mshr_tl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  tgt_t          ents [DEPTH],
    input  logic [CW-1:0] cnt,
    input  logic          inval,
    output tgt_t          sel_vec [DEPTH],
    output logic [CW-1:0] sel_cnt,
    output tgt_t          keep_vec [DEPTH],
    output logic [CW-1:0] keep_cnt,
    output logic          sel_alloc,
    output logic          bad
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            sel_vec[i]  = '0;
            keep_vec[i] = '0;
        end
        sel_cnt   = '0;
        keep_cnt  = '0;
        sel_alloc = 1'b0;
        bad       = inval && (cnt == '0);
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt) begin
                if (inval && (i == 0) && (ents[i].src != SRC_CPU)) bad = 1'b1;
                if (inval && (i > 0) && tail_illegal(ents[i].src)) bad = 1'b1;
                if (!inval || inval_takes(i, ents[i].src)) begin
                    sel_vec[sel_cnt[IW-1:0]] = ents[i];
                    sel_cnt   = sel_cnt + 1'b1;
                    sel_alloc = sel_alloc | ents[i].alloc;
                end else begin
                    keep_vec[keep_cnt[IW-1:0]] = ents[i];
                    keep_cnt = keep_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mshr_tl_stream.sv
module mshr_tl_stream
    import mshr_tl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  tgt_t          load_vec [DEPTH],
    input  logic [CW-1:0] load_cnt,
    input  logic          load_alloc,
    input  logic          out_ready,
    output tgt_t          out_t,
    output logic          out_valid,
    output logic          out_first,
    output logic          out_alloc
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tgt_t          sbuf_q [DEPTH];
    logic [CW-1:0] rd_q;
    logic [CW-1:0] cnt_q;
    logic          alloc_q;

    assign out_valid = (cnt_q != '0);
    assign out_t     = sbuf_q[rd_q[IW-1:0]];
    assign out_first = (rd_q == '0);
    assign out_alloc = alloc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= '0;
            cnt_q   <= '0;
            alloc_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) sbuf_q[i] <= '0;
        end else if (load) begin
            sbuf_q  <= load_vec;
            cnt_q   <= load_cnt;
            rd_q    <= '0;
            alloc_q <= load_alloc;
        end else if (out_valid && out_ready) begin
            if (rd_q + 1'b1 == cnt_q) begin
                rd_q  <= '0;
                cnt_q <= '0;
            end else begin
                rd_q <= rd_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mshr_tgt_lists.sv
module mshr_tgt_lists
    import mshr_tl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic             ins_defer,
    input  logic [1:0]       ins_src,
    input  logic [ORD_W-1:0] ins_order,
    input  logic [ID_W-1:0]  ins_id,
    input  logic             ins_alloc,
    input  logic             ins_pend,
    output logic             ins_stall,
    input  logic             resp_valid,
    input  logic             resp_inval,
    output logic             resp_ready,
    output logic             resp_err,
    input  logic             promote_req,
    output logic             prom_none,
    input  logic             clr_pend_pri,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_src,
    output logic [ORD_W-1:0] out_order,
    output logic [ID_W-1:0]  out_id,
    output logic             out_pend,
    output logic             out_first,
    output logic             out_alloc,
    output logic [CW-1:0]    pri_cnt,
    output logic [CW-1:0]    def_cnt,
    output logic             pri_alloc_any,
    output logic             pri_pend_any,
    output logic             def_alloc_any
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tgt_t          pri_ents [DEPTH];
    tgt_t          def_ents [DEPTH];
    tgt_t          sel_vec  [DEPTH];
    tgt_t          keep_vec [DEPTH];
    tgt_t          cat_vec  [DEPTH];
    tgt_t          pri_load_vec [DEPTH];
    tgt_t          new_t;
    tgt_t          out_t;
    logic [CW-1:0] sel_cnt, keep_cnt, pri_load_cnt;
    logic [CW:0]   cat_sum;
    logic          sel_alloc, split_bad, pri_full, def_full, def_pend_any;
    logic          resp_fire, prom_act, prom_do, op_busy, pri_load;

    assign new_t = '{src: src_e'(ins_src), ord: ins_order, id: ins_id,
                     alloc: ins_alloc, pend: ins_pend};

    // One list-rewriting operation per cycle: response, then promotion.
    assign resp_fire = resp_valid && resp_ready;
    assign prom_act  = promote_req && !resp_fire;
    assign cat_sum   = {1'b0, pri_cnt} + {1'b0, def_cnt};
    assign prom_none = prom_act &&
                       (((pri_cnt == '0) && (def_cnt == '0)) || (cat_sum > (CW+1)'(DEPTH)));
    assign prom_do   = prom_act && !prom_none;
    assign op_busy   = resp_fire || prom_act;
    assign ins_stall = ins_valid && (op_busy || (ins_defer ? def_full : pri_full));
    assign resp_err  = resp_fire && split_bad;

    // Deferred entries placed right behind the remaining active ones.
    always_comb begin
        int k;
        cat_vec = pri_ents;
        for (int i = 0; i < DEPTH; i++) begin
            k = i - int'(pri_cnt);
            if ((k >= 0) && (k < int'(def_cnt))) cat_vec[i] = def_ents[k[IW-1:0]];
        end
    end

    assign pri_load     = resp_fire || prom_do;
    assign pri_load_vec = resp_fire ? keep_vec : cat_vec;
    assign pri_load_cnt = resp_fire ? keep_cnt : cat_sum[CW-1:0];

    mshr_tl_split #(.DEPTH(DEPTH), .CW(CW)) split_i (
        .ents(pri_ents), .cnt(pri_cnt), .inval(resp_inval),
        .sel_vec(sel_vec), .sel_cnt(sel_cnt),
        .keep_vec(keep_vec), .keep_cnt(keep_cnt),
        .sel_alloc(sel_alloc), .bad(split_bad)
    );

    mshr_tl_list #(.DEPTH(DEPTH), .CW(CW)) pri_i (
        .clk(clk), .rst(rst),
        .push(ins_valid && !ins_defer && !op_busy), .push_t(new_t),
        .load(pri_load), .load_vec(pri_load_vec), .load_cnt(pri_load_cnt),
        .clr_pend(clr_pend_pri),
        .ents(pri_ents), .cnt(pri_cnt), .full(pri_full),
        .alloc_any(pri_alloc_any), .pend_any(pri_pend_any)
    );

    // A promotion empties the deferred list; contents past the count are don't-care.
    mshr_tl_list #(.DEPTH(DEPTH), .CW(CW)) def_i (
        .clk(clk), .rst(rst),
        .push(ins_valid && ins_defer && !op_busy), .push_t(new_t),
        .load(prom_do), .load_vec(cat_vec), .load_cnt('0),
        .clr_pend(1'b0),
        .ents(def_ents), .cnt(def_cnt), .full(def_full),
        .alloc_any(def_alloc_any), .pend_any(def_pend_any)
    );

    mshr_tl_stream #(.DEPTH(DEPTH), .CW(CW)) stream_i (
        .clk(clk), .rst(rst),
        .load(resp_fire && (sel_cnt != '0)), .load_vec(sel_vec),
        .load_cnt(sel_cnt), .load_alloc(sel_alloc),
        .out_ready(out_ready), .out_t(out_t), .out_valid(out_valid),
        .out_first(out_first), .out_alloc(out_alloc)
    );

    assign resp_ready = !out_valid;
    assign out_src    = out_t.src;
    assign out_order  = out_t.ord;
    assign out_id     = out_t.id;
    assign out_pend   = out_t.pend;
endmodule

// File: rtl/mshr_tgt_lists_chk.sv
module mshr_tgt_lists_chk
    import mshr_tl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             ins_defer,
    input logic [1:0]       ins_src,
    input logic [ORD_W-1:0] ins_order,
    input logic [ID_W-1:0]  ins_id,
    input logic             ins_alloc,
    input logic             ins_pend,
    input logic             ins_stall,
    input logic             resp_valid,
    input logic             resp_inval,
    input logic             resp_ready,
    input logic             resp_err,
    input logic             promote_req,
    input logic             prom_none,
    input logic             clr_pend_pri,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_src,
    input logic [ORD_W-1:0] out_order,
    input logic [ID_W-1:0]  out_id,
    input logic             out_pend,
    input logic             out_first,
    input logic             out_alloc,
    input logic [CW-1:0]    pri_cnt,
    input logic [CW-1:0]    def_cnt,
    input logic             pri_alloc_any,
    input logic             pri_pend_any,
    input logic             def_alloc_any
);
    // R3
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_ready && !resp_inval |=> pri_cnt == '0);

    // R4
    inval_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_ready && resp_inval && (pri_cnt != '0) |=> pri_cnt < $past(pri_cnt));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_order) && $stable(out_src));

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !resp_ready);

    // R9
    promote_move_chk: assert property (@(posedge clk) disable iff (rst)
        promote_req && !(resp_valid && resp_ready) && !prom_none |=>
        (def_cnt == '0) && ({1'b0, pri_cnt} == {1'b0, $past(pri_cnt)} + {1'b0, $past(def_cnt)}));

    // R10
    promote_idle_chk: assert property (@(posedge clk) disable iff (rst)
        prom_none |=> $stable(pri_cnt) && $stable(def_cnt));

    // R11
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_pend_pri |=> !pri_pend_any);

    // R12
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (pri_cnt <= CW'(DEPTH)) && (def_cnt <= CW'(DEPTH)));
endmodule

bind mshr_tgt_lists mshr_tgt_lists_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/mshr_tgt_lists_tb_top.sv
`timescale 1ns/1ps
module mshr_tgt_lists_tb_top;
    import mshr_tl_pkg::*;

    localparam int BD  = 4;
    localparam int BCW = $clog2(BD + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             ins_valid = 0, ins_defer = 0, ins_alloc = 0, ins_pend = 0;
    logic [1:0]       ins_src = 0;
    logic [ORD_W-1:0] ins_order = 0;
    logic [ID_W-1:0]  ins_id = 0;
    logic             resp_valid = 0, resp_inval = 0, promote_req = 0, clr_pend_pri = 0;
    logic             out_ready = 0;
    logic             ins_stall, resp_ready, resp_err, prom_none, out_valid;
    logic [1:0]       out_src;
    logic [ORD_W-1:0] out_order;
    logic [ID_W-1:0]  out_id;
    logic             out_pend, out_first, out_alloc;
    logic [BCW-1:0]   pri_cnt, def_cnt;
    logic             pri_alloc_any, pri_pend_any, def_alloc_any;

    mshr_tgt_lists #(.DEPTH(BD)) dut_i (.*);

    int nchk = 0;
    int nerr = 0;

    tgt_t mp[$];
    tgt_t md[$];
    tgt_t ms[$];
    bit   m_first = 1'b0;
    bit   m_alloc = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit q_alloc(tgt_t q[$]);
        bit r = 0;
        foreach (q[i]) r |= q[i].alloc;
        return r;
    endfunction

    function automatic bit q_pend(tgt_t q[$]);
        bit r = 0;
        foreach (q[i]) r |= q[i].pend;
        return r;
    endfunction

    task automatic step(input bit iv, input bit idef, input int isrc, input int iord,
                        input int iid, input bit ial, input bit ipd, input bit rv,
                        input bit rinv, input bit pr, input bit cp, input bit ordy);
        bit   rf, pa, en, est, eer, full_sel;
        tgt_t t;
        tgt_t keep[$];
        @(negedge clk);
        ins_valid = iv; ins_defer = idef; ins_src = 2'(isrc); ins_order = 8'(iord);
        ins_id = 6'(iid); ins_alloc = ial; ins_pend = ipd;
        resp_valid = rv; resp_inval = rinv; promote_req = pr; clr_pend_pri = cp;
        out_ready = ordy;
        #1;
        t = '{src: src_e'(ins_src), ord: ins_order, id: ins_id, alloc: ial, pend: ipd};
        rf = rv && (ms.size() == 0);
        pa = pr && !rf;
        en = pa && (((mp.size() == 0) && (md.size() == 0)) || (mp.size() + md.size() > BD));
        full_sel = idef ? (md.size() >= BD) : (mp.size() >= BD);
        est = iv && (rf || pa || full_sel);
        eer = rf && rinv && (mp.size() == 0 || mp[0].src != SRC_CPU);
        if (rf && rinv)
            foreach (mp[i]) if (i > 0 && mp[i].src != SRC_CPU && mp[i].src != SRC_SNOOP) eer = 1;

        chk(ins_stall == est, "R2 ins_stall", ins_stall, est);
        chk(resp_ready == (ms.size() == 0), "R6 resp_ready", resp_ready, ms.size() == 0);
        chk(resp_err == eer, "R5 resp_err", resp_err, eer);
        chk(prom_none == en, "R10 prom_none", prom_none, en);
        chk(int'(pri_cnt) == mp.size(), "R3 R4 R8 R9 pri_cnt", pri_cnt, mp.size());
        chk(int'(def_cnt) == md.size(), "R2 R8 def_cnt", def_cnt, md.size());
        chk(pri_alloc_any == q_alloc(mp), "R12 pri_alloc_any", pri_alloc_any, q_alloc(mp));
        chk(def_alloc_any == q_alloc(md), "R12 def_alloc_any", def_alloc_any, q_alloc(md));
        chk(pri_pend_any == q_pend(mp), "R11 pri_pend_any", pri_pend_any, q_pend(mp));
        chk(out_valid == (ms.size() > 0), "R6 out_valid", out_valid, ms.size() > 0);
        if (ms.size() > 0) begin
            chk({out_src, out_order, out_id, out_pend} ==
                {ms[0].src, ms[0].ord, ms[0].id, ms[0].pend},
                "R3 R4 served target", {out_src, out_order, out_id},
                {ms[0].src, ms[0].ord, ms[0].id});
            chk(out_first == m_first, "R7 out_first", out_first, m_first);
            if (m_first) chk(out_alloc == m_alloc, "R7 out_alloc", out_alloc, m_alloc);
        end

        if (ms.size() > 0 && ordy) begin
            void'(ms.pop_front());
            m_first = 0;
        end
        if (rf) begin
            m_alloc = 0;
            foreach (mp[i]) begin
                if (!rinv || i == 0 || mp[i].src == SRC_SNOOP) begin
                    ms.push_back(mp[i]);
                    m_alloc |= mp[i].alloc;
                end else begin
                    keep.push_back(mp[i]);
                end
            end
            mp = keep;
            m_first = 1;
        end else if (pa && !en) begin
            foreach (md[i]) mp.push_back(md[i]);
            md = {};
        end
        if (iv && !est) begin
            if (idef) md.push_back(t);
            else mp.push_back(t);
        end
        if (cp) foreach (mp[i]) mp[i].pend = 1'b0;
    endtask

    task automatic idle(input bit ordy);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ordy);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(pri_cnt == 0 && def_cnt == 0, "R1 counts after reset", pri_cnt + def_cnt, 0);
        chk(!out_valid && resp_ready, "R1 handshake after reset", out_valid, 0);
        chk(!pri_alloc_any && !pri_pend_any && !def_alloc_any, "R1 flags after reset",
            pri_alloc_any + pri_pend_any + def_alloc_any, 0);

        // Directed: build lists, append-promote, invalidating split (R4, R9, R2)
        step(1, 0, 0, 10, 1, 0, 1, 0, 0, 0, 0, 1);
        step(1, 0, 1, 11, 2, 1, 1, 0, 0, 0, 0, 1);
        step(1, 0, 0, 12, 3, 0, 0, 0, 0, 0, 0, 1);
        step(1, 1, 0, 13, 4, 1, 1, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step(1, 0, 0, 14, 5, 0, 0, 0, 0, 0, 0, 1);
        step(1, 1, 2, 15, 6, 1, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
        idle(0); idle(0); idle(1); idle(1); idle(1);
        // R11 clear, then R3 ordinary flush
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        idle(1); idle(1); idle(1); idle(1);
        // R8 move into empty active list, R10 both empty
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        idle(1); idle(1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        // R5: empty list, then non-CPU head
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1);
        idle(1);
        step(1, 0, 2, 20, 7, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1);
        idle(1); idle(1);

        // Random traffic covering all requirements
        for (int c = 0; c < 4000; c++) begin
            int s = $urandom_range(99);
            int src = (s < 55) ? 0 : (s < 90) ? 1 : (s < 97) ? 2 : 3;
            step($urandom_range(99) < 50, $urandom_range(99) < 30, src,
                 $urandom_range(255), $urandom_range(63), $urandom_range(1),
                 $urandom_range(1), $urandom_range(99) < 10, $urandom_range(1),
                 $urandom_range(99) < 8, $urandom_range(99) < 5,
                 $urandom_range(99) < 70);
        end
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule